// File: doc/BRIEF.md
# Security-Banked Interrupt Group Enable

This block holds the two global enables of an interrupt distributor: one for the secure interrupt group and one for the non-secure group. A register bus reaches both through a single register location, and every access carries a security attribute. The attribute changes the bit layout. A secure access sees both enables. A non-secure access sees only the non-secure enable, and that enable sits in the lowest bit. A lock input freezes the secure enable. The non-secure enable stays writable from both kinds of access while the lock is high.

The enables decide whether the external interrupt inputs may change pending state. Each input has a group bit on a port. A rising edge on an input sets its pending latch only if that input's group is enabled in that cycle. An edge that arrives while the group is disabled is dropped for good, and holding the input high does not replay it later. Software can clear any pending latch with a per-line strobe, whatever the enables are.

Each pending latch is a two-state machine. State `PS_IDLE` moves to `PS_PEND` on a qualified edge (transition T_SET). State `PS_PEND` returns to `PS_IDLE` on a clear strobe when no qualified edge occurs in the same cycle (transition T_CLR). In every other case the state holds (transition T_HOLD).

Top module: `gde_distributor_en`

## Requirements
- R1: After reset, `en_secure`, `en_nonsecure`, every bit of `pending` and `bus_rdata` are all 0.
- R2: A read strobed with `bus_secure`=1 returns, in the cycle after the strobe, bit 1 = non-secure enable and bit 0 = secure enable, with bits 31:2 = 0. The value returned is the one held before any write sampled in the same cycle.
- R3: A read strobed with `bus_secure`=0 returns, in the cycle after the strobe, bit 0 = non-secure enable, with bits 31:1 = 0.
- R4: A write with `bus_secure`=1 loads `bus_wdata[1]` into the non-secure enable and `bus_wdata[0]` into the secure enable, on the clock edge that samples the strobe. Bits 31:2 are ignored.
- R5: A write with `bus_secure`=0 loads `bus_wdata[0]` into the non-secure enable. The secure enable is unchanged, and bits 31:1 are ignored.
- R6: While `lock_in` is 1, writes leave the secure enable unchanged. The non-secure enable is still written by both secure and non-secure writes.
- R7: A rising edge on `irq_in[i]` (0 in the previous sampled cycle, 1 now) sets `pending[i]` on that same sampling edge when its group is enabled. The group is selected by `irq_group[i]`: 1 = secure, 0 = non-secure.
- R8: While a line's group enable is 0, an edge on that line leaves `pending[i]` unchanged. The edge is discarded, and it is not replayed when the group is enabled later.
- R9: An edge is qualified by the enable value held before a write in the same cycle. A write that enables a group does not admit an edge in its own cycle, and a write that disables a group does not block one.
- R10: `pend_clr[i]` clears `pending[i]` regardless of the enables. When a clear and a qualified edge on the same line coincide, the line ends up pending.
- R11: After a clear, an input that stays high does not set `pending[i]` again until it has gone low and risen once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe of the enable register |
| bus_wr | input | 1 | Write strobe of the enable register |
| bus_secure | input | 1 | Security attribute of the access (1 = secure) |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after `bus_rd` |
| lock_in | input | 1 | Freezes the secure enable while high |
| irq_in | input | N_IRQ (8) | External interrupt inputs |
| irq_group | input | N_IRQ (8) | Group of each input (1 = secure) |
| pend_clr | input | N_IRQ (8) | Per-line pending clear strobes |
| pending | output | N_IRQ (8) | Pending latch state |
| en_secure | output | 1 | Secure group enable |
| en_nonsecure | output | 1 | Non-secure group enable |

## Verification
Two functions can fall in the same cycle: a bus write that flips a group enable, and a rising edge on an input of that group. The bench produces both cases. In one, a write enables the group in the cycle the edge arrives, and the line must stay idle. In the other, a write disables the group in the edge's cycle, and the line must become pending. Two further collisions are provoked and checked at the ports the cycle after: a clear strobe that meets a qualified edge on the same line must leave the line pending, and a read in the same cycle as a write must return the value held before the write.

// File: rtl/gde_pkg.sv
package gde_pkg;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_PEND = 1'b1
    } pend_state_t;

    typedef enum logic {
        ACC_NONSEC = 1'b0,
        ACC_SEC    = 1'b1
    } acc_kind_t;

    // Bit positions that software decodes, per access kind
    localparam int unsigned SV_NS_BIT = 1;
    localparam int unsigned SV_S_BIT  = 0;
    localparam int unsigned NV_NS_BIT = 0;

endpackage

// File: rtl/gde_bank_reg.sv
module gde_bank_reg
    import gde_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic              secure,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock,
    output logic [DATA_W-1:0] rdata,
    output logic              en_s,
    output logic              en_ns
);

    localparam int unsigned HI_W = DATA_W - 2;

    acc_kind_t         kind;
    logic [DATA_W-1:0] view;
    logic              unused_hi;

    assign kind      = secure ? ACC_SEC : ACC_NONSEC;
    assign unused_hi = ^wdata[DATA_W-1:2];

    // Read view selected by the access attribute
    always_comb begin
        view = '0;
        unique case (kind)
            ACC_SEC: begin
                view[SV_NS_BIT] = en_ns;
                view[SV_S_BIT]  = en_s;
            end
            ACC_NONSEC: begin
                view[NV_NS_BIT] = en_ns;
            end
        endcase
    end

    // Enable bits: secure bit obeys the lock, non-secure bit never does
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_s  <= 1'b0;
            en_ns <= 1'b0;
        end else if (wr) begin
            unique case (kind)
                ACC_SEC: begin
                    en_ns <= wdata[SV_NS_BIT];
                    if (!lock) begin
                        en_s <= wdata[SV_S_BIT];
                    end
                end
                ACC_NONSEC: begin
                    en_ns <= wdata[NV_NS_BIT];
                end
            endcase
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= {HI_W + 2{1'b0}};
        end else if (rd) begin
            rdata <= view;
        end
    end

endmodule

// File: rtl/gde_pend_cell.sv
module gde_pend_cell
    import gde_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic grp_sec,
    input  logic en_s,
    input  logic en_ns,
    input  logic clr,
    output logic pending
);

    pend_state_t state_q;
    pend_state_t state_d;
    logic        irq_q;
    logic        rise;
    logic        grp_on;
    logic        set_ok;

    assign rise   = irq & ~irq_q;
    assign grp_on = grp_sec ? en_s : en_ns;
    assign set_ok = rise & grp_on;

    // Input history, tracked whether or not the group is enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_SET, T_CLR, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (set_ok) begin
                    state_d = PS_PEND;
                end
            end
            PS_PEND: begin
                if (clr && !set_ok) begin
                    state_d = PS_IDLE;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            PS_IDLE: pending = 1'b0;
            PS_PEND: pending = 1'b1;
        endcase
    end

endmodule

// File: rtl/gde_distributor_en.sv
module gde_distributor_en
    import gde_pkg::*;
#(
    parameter int unsigned N_IRQ  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_secure,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lock_in,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic [N_IRQ-1:0]  irq_group,
    input  logic [N_IRQ-1:0]  pend_clr,
    output logic [N_IRQ-1:0]  pending,
    output logic              en_secure,
    output logic              en_nonsecure
);

    gde_bank_reg #(.DATA_W(DATA_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .secure (bus_secure),
        .wdata  (bus_wdata),
        .lock   (lock_in),
        .rdata  (bus_rdata),
        .en_s   (en_secure),
        .en_ns  (en_nonsecure)
    );

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        gde_pend_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq     (irq_in[i]),
            .grp_sec (irq_group[i]),
            .en_s    (en_secure),
            .en_ns   (en_nonsecure),
            .clr     (pend_clr[i]),
            .pending (pending[i])
        );
    end

endmodule

// File: rtl/gde_checker.sv
module gde_checker #(
    parameter int unsigned N_IRQ  = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_secure,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              lock_in,
    input logic [N_IRQ-1:0]  irq_in,
    input logic [N_IRQ-1:0]  irq_group,
    input logic [N_IRQ-1:0]  pend_clr,
    input logic [N_IRQ-1:0]  pending,
    input logic              en_secure,
    input logic              en_nonsecure
);

    localparam int unsigned Z2 = DATA_W - 2;
    localparam int unsigned Z1 = DATA_W - 1;

    logic [N_IRQ-1:0] off_mask;
    assign off_mask = (irq_group & {N_IRQ{~en_secure}}) | (~irq_group & {N_IRQ{~en_nonsecure}});

    a_r2_secure_view: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_secure) |=> (bus_rdata == {{Z2{1'b0}}, $past(en_nonsecure), $past(en_secure)}));

    a_r3_nonsec_view: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_secure) |=> (bus_rdata == {{Z1{1'b0}}, $past(en_nonsecure)}));

    a_r4_secure_write_ns: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_secure) |=> (en_nonsecure == $past(bus_wdata[1])));

    a_r5_nonsec_write_spares_s: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_secure) |=> (en_secure == $past(en_secure)));

    a_r6_lock_freezes_s: assert property (@(posedge clk) disable iff (!rst_n)
        lock_in |=> (en_secure == $past(en_secure)));

    a_r7_set_needs_high_input: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & ~$past(pending) & ~$past(irq_in)) == '0));

    a_r8_disabled_group_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & ~$past(pending) & $past(off_mask)) == '0));

    a_r10_clear_with_low_input: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_clr & ~irq_in) & pending) == '0));

endmodule

bind gde_distributor_en gde_checker #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_secure   (bus_secure),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .lock_in      (lock_in),
    .irq_in       (irq_in),
    .irq_group    (irq_group),
    .pend_clr     (pend_clr),
    .pending      (pending),
    .en_secure    (en_secure),
    .en_nonsecure (en_nonsecure)
);

// File: tb/gde_distributor_en_bench.sv
module gde_distributor_en_bench;

    localparam int N  = 8;
    localparam int DW = 32;

    typedef struct {
        logic [DW-1:0] value;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_secure = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          lock_in = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  irq_group = 8'b1111_0000;
    logic [N-1:0]  pend_clr = '0;
    logic [N-1:0]  pending;
    logic          en_secure;
    logic          en_nonsecure;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic rd_seen = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    gde_distributor_en #(.N_IRQ(N), .DATA_W(DW)) u_gde_distributor_en (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_secure(bus_secure), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_in(lock_in), .irq_in(irq_in), .irq_group(irq_group),
        .pend_clr(pend_clr), .pending(pending), .en_secure(en_secure),
        .en_nonsecure(en_nonsecure)
    );

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: a read strobed at a posedge is compared at the next negedge
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen && !done) begin
            if (sb.size() == 0) begin
                chk(bus_rdata, 'x, "scoreboard empty");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(bus_rdata, e.value, e.tag);
            end
        end
    end

    // Drivers: inputs are set at a negedge and last one cycle
    task automatic cyc();
        @(negedge clk);
        bus_rd   = 1'b0;
        bus_wr   = 1'b0;
        pend_clr = '0;
    endtask

    task automatic rd(input logic sec, input logic [DW-1:0] exp, input string tag);
        exp_t e;
        e.value = exp;
        e.tag   = tag;
        sb.push_back(e);
        bus_rd     = 1'b1;
        bus_secure = sec;
        cyc();
    endtask

    task automatic wr(input logic sec, input logic [DW-1:0] d);
        bus_wr     = 1'b1;
        bus_secure = sec;
        bus_wdata  = d;
        cyc();
    endtask

    task automatic chk_pend(input logic [N-1:0] exp, input string tag);
        chk({{(DW-N){1'b0}}, pending}, {{(DW-N){1'b0}}, exp}, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({30'b0, en_nonsecure, en_secure}, 0, "R1 enables after reset");
        chk_pend(8'h00, "R1 pending after reset");
        chk(bus_rdata, 0, "R1 rdata after reset");
        rd(1'b1, 32'h0, "R2 secure read after reset");

        // R8: edge on line 0 (non-secure group) while disabled
        irq_in[0] = 1'b1; cyc();
        chk_pend(8'h00, "R8 edge while disabled");

        // R5: non-secure write with junk upper bits
        wr(1'b0, 32'hFFFF_FFFF);
        chk({30'b0, en_nonsecure, en_secure}, 32'h2, "R5 ns write leaves secure enable");
        rd(1'b0, 32'h1, "R3 nonsecure view");
        rd(1'b1, 32'h2, "R2 secure view ns only");
        chk_pend(8'h00, "R8 no replay of dropped edge");

        // R7: fresh edge on line 0 now admitted; line 4 secure still off
        irq_in[0] = 1'b0; cyc();
        irq_in[0] = 1'b1; irq_in[4] = 1'b1; cyc();
        chk_pend(8'h01, "R7 edge sets, R8 secure line blocked");

        // R10/R11: clear with input held high
        pend_clr[0] = 1'b1; cyc();
        chk_pend(8'h00, "R10 clear with enables on");
        cyc(); cyc();
        chk_pend(8'h00, "R11 held input no reset");

        // R4: secure write with junk upper bits
        wr(1'b1, 32'hA5A5_A5A7);
        rd(1'b1, 32'h3, "R4 secure write both bits");
        irq_in[4] = 1'b0; cyc();
        irq_in[4] = 1'b1; cyc();
        chk_pend(8'h10, "R7 secure line sets when enabled");

        // R6: lock behaviour
        lock_in = 1'b1;
        wr(1'b1, 32'h0);
        rd(1'b1, 32'h1, "R6 lock keeps secure, ns written");
        wr(1'b0, 32'h1);
        rd(1'b1, 32'h3, "R6 ns write under lock");
        wr(1'b1, 32'h2);
        rd(1'b1, 32'h3, "R6 secure bit frozen");
        lock_in = 1'b0;
        wr(1'b1, 32'h0);
        rd(1'b1, 32'h0, "R4 write after unlock");

        // R10: clear with no enable
        pend_clr[4] = 1'b1; cyc();
        chk_pend(8'h00, "R10 clear with enables off");

        // R9: enabling write and edge in the same cycle
        bus_wr = 1'b1; bus_secure = 1'b1; bus_wdata = 32'h3; irq_in[1] = 1'b1; cyc();
        chk_pend(8'h00, "R9 enable in edge cycle");
        // R9: disabling write and edge in the same cycle
        bus_wr = 1'b1; bus_secure = 1'b1; bus_wdata = 32'h0; irq_in[2] = 1'b1; cyc();
        chk_pend(8'h04, "R9 disable in edge cycle");

        // R10: clear meets qualified edge
        wr(1'b1, 32'h3);
        pend_clr[2] = 1'b1; irq_in[2] = 1'b0; cyc();
        chk_pend(8'h00, "R10 clear line 2");
        pend_clr[2] = 1'b1; irq_in[2] = 1'b1; cyc();
        chk_pend(8'h04, "R10 edge wins over clear");

        // R2: read and write in the same cycle
        bus_wr = 1'b1; bus_wdata = 32'h0;
        rd(1'b1, 32'h3, "R2 read returns pre-write value");
        rd(1'b1, 32'h0, "R2 read after write");
        cyc(); cyc();

        if (sb.size() != 0) chk(sb.size(), 0, "scoreboard leftover");
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule